// File: doc/BRIEF.md
# Shared-Datapath Media Arithmetic Unit

This block is a pipelined arithmetic unit for pixel and sample processing. A 3-bit operation code picks one of six functions on two unsigned operands: sum, difference, product, multiply-accumulate, weighted blend of two samples, and a running sum of absolute differences. Every function travels through the same three registered stages: a radix-4 recoded partial-product generator, a reduction stage that merges the partial products with a linear term, and an accumulation stage that owns the running total and the output register.

One beat may be issued per clock. A beat is accepted when `in_valid` is high, and its result leaves the block a fixed three rising edges later with `out_valid`. The stage-one registers of a sub-unit that the current operation does not need keep their contents, so that unit's logic sees no input changes. One accumulator is shared by the multiply-accumulate and the absolute-difference modes. `acc_clr` travels down the pipeline with its beat, so a clear takes effect in issue order.

Top module: `mm_arith_unit`

## Requirements
- R1: Code 000 gives opa + opb, zero-extended to the result width.
- R2: Code 010 gives opa - opb as a two's-complement value in the result width (0 - 255 gives 0xFFFF01 at 24 bits).
- R3: Code 001 gives the unsigned product opa * opb.
- R4: Code 111 adds opa * opb to the shared accumulator and outputs the new accumulator value.
- R5: Code 100 adds |opa - opb| to the shared accumulator and outputs the new accumulator value.
- R6: Code 110 gives (opa*(256-wgt) + opb*wgt) >> 8 with an 8-bit weight; wgt = 0 returns opa exactly.
- R7: Codes 011 and 101 drive result to zero and leave out_valid low for that beat.
- R8: A beat accepted at a rising edge sets out_valid and result on the third rising edge from and including that one; beats may be issued on every cycle.
- R9: acc_clr empties the accumulator before the beat it accompanies is applied; with in_valid low it still empties the accumulator, in order with beats issued before and after it.
- R10: A beat whose operation does not multiply leaves the partial-product registers unchanged, and a beat that uses no add/subtract term leaves the linear-term register unchanged; later results are unaffected.
- R11: During reset result is zero, out_valid is low and the accumulator is empty.
- R12: A cycle without an accepted beat gives out_valid low three edges later and result keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat strobe; inputs are taken when high |
| op | input | 3 | Operation code |
| acc_clr | input | 1 | Empty the accumulator ahead of this beat |
| opa | input | W | First unsigned operand |
| opb | input | W | Second unsigned operand |
| wgt | input | WGT_W | Blend weight for code 110 |
| result | output | ACC_W | Result, two's complement |
| out_valid | output | 1 | Result is from a legal accepted beat |

## Verification
The bench targets the extremes of each mode. It checks 255*255 for radix-4 digit errors in the top recoded group and 0 - 255 for sign handling. For the blend it uses weights 0, 128 and 255 and a falling pair where opb < opa, which exposes a logical shift in place of an arithmetic one. A bare clear, a clear riding on a beat, and MAC and SAD sharing the accumulator catch a clear applied out of order or one stage off. Illegal codes and idle gaps catch a design that raises valid or disturbs the held result. Multiplies following runs of add-type beats expose a frozen register that leaks stale or gated data into the product.

// File: rtl/mmau_pkg.sv
package mmau_pkg;

  localparam logic [2:0] OP_ADD  = 3'b000;
  localparam logic [2:0] OP_MUL  = 3'b001;
  localparam logic [2:0] OP_SUB  = 3'b010;
  localparam logic [2:0] OP_SAD  = 3'b100;
  localparam logic [2:0] OP_LERP = 3'b110;
  localparam logic [2:0] OP_MAC  = 3'b111;

  function automatic logic f_uses_mul(input logic [2:0] code);
    return (code == OP_MUL) || (code == OP_MAC) || (code == OP_LERP);
  endfunction

  function automatic logic f_uses_lin(input logic [2:0] code);
    return (code == OP_ADD) || (code == OP_SUB) || (code == OP_SAD) || (code == OP_LERP);
  endfunction

  function automatic logic f_accum(input logic [2:0] code);
    return (code == OP_MAC) || (code == OP_SAD);
  endfunction

  function automatic logic f_legal(input logic [2:0] code);
    return (code != 3'b011) && (code != 3'b101);
  endfunction

endpackage

// File: rtl/mmau_booth_gen.sv
module mmau_booth_gen #(
  parameter int MC_W  = 10,
  parameter int MR_W  = 9,
  parameter int ACC_W = 24,
  parameter int ND    = (MR_W + 1) / 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic signed [MC_W-1:0]       mc,
  input  logic        [MR_W-1:0]       mr,
  output logic        [ND-1:0][ACC_W-1:0] pp_q
);

  localparam int EXT_W = 2 * ND + 1;

  logic [EXT_W-1:0]             mr_ext;
  logic signed [ACC_W-1:0]      mc_ext;
  logic [ND-1:0][ACC_W-1:0]     pp_d;

  always_comb begin
    mr_ext = '0;
    mr_ext[MR_W:1] = mr;
    mc_ext = {{(ACC_W-MC_W){mc[MC_W-1]}}, mc};
  end

  for (genvar g = 0; g < ND; g++) begin : g_digit
    logic [2:0]              tri_bits;
    logic signed [ACC_W-1:0] mag;
    assign tri_bits = mr_ext[2*g+2 -: 3];
    always_comb begin
      case (tri_bits)
        3'b001, 3'b010: mag = mc_ext;
        3'b011:         mag = mc_ext <<< 1;
        3'b100:         mag = -(mc_ext <<< 1);
        3'b101, 3'b110: mag = -mc_ext;
        default:        mag = '0;
      endcase
      pp_d[g] = mag <<< (2 * g);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pp_q <= '0;
    else if (load) pp_q <= pp_d;
  end

endmodule

// File: rtl/mmau_reduce.sv
module mmau_reduce import mmau_pkg::*; #(
  parameter int ND    = 5,
  parameter int ACC_W = 24,
  parameter int WGT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [2:0]               code,
  input  logic [ND-1:0][ACC_W-1:0] pp_q,
  input  logic signed [ACC_W-1:0]  lin_q,
  output logic signed [ACC_W-1:0]  val_q
);

  logic signed [ACC_W-1:0] prod;
  logic signed [ACC_W-1:0] val_d;

  always_comb begin
    prod = '0;
    for (int i = 0; i < ND; i++) prod = prod + signed'(pp_q[i]);
    case (code)
      OP_MUL, OP_MAC: val_d = prod;
      OP_LERP:        val_d = lin_q + (prod >>> WGT_W);
      default:        val_d = lin_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  val_q <= '0;
    else if (en) val_q <= val_d;
  end

endmodule

// File: rtl/mmau_accum.sv
module mmau_accum import mmau_pkg::*; #(
  parameter int ACC_W = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s2_valid,
  input  logic [2:0]              s2_code,
  input  logic                    s2_clr,
  input  logic signed [ACC_W-1:0] s2_val,
  output logic [ACC_W-1:0]        result,
  output logic                    out_valid
);

  logic signed [ACC_W-1:0] acc_q, acc_d, acc_base;
  logic        [ACC_W-1:0] res_q, res_d;
  logic                    ov_d, ov_q;

  always_comb begin
    acc_base = s2_clr ? '0 : acc_q;
    acc_d    = acc_base;
    res_d    = res_q;
    ov_d     = 1'b0;
    if (s2_valid) begin
      if (!f_legal(s2_code)) begin
        res_d = '0;
      end else if (f_accum(s2_code)) begin
        acc_d = acc_base + s2_val;
        res_d = acc_d;
        ov_d  = 1'b1;
      end else begin
        res_d = s2_val;
        ov_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      res_q <= '0;
      ov_q  <= 1'b0;
    end else begin
      acc_q <= acc_d;
      res_q <= res_d;
      ov_q  <= ov_d;
    end
  end

  assign result    = res_q;
  assign out_valid = ov_q;

endmodule

// File: rtl/mm_arith_unit.sv
module mm_arith_unit import mmau_pkg::*; #(
  parameter int W     = 8,
  parameter int WGT_W = 8,
  parameter int ACC_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic              acc_clr,
  input  logic [W-1:0]      opa,
  input  logic [W-1:0]      opb,
  input  logic [WGT_W-1:0]  wgt,
  output logic [ACC_W-1:0]  result,
  output logic              out_valid
);

  localparam int MR_W = ((W > WGT_W) ? W : WGT_W) + 1;
  localparam int MC_W = W + 2;
  localparam int ND   = (MR_W + 1) / 2;

  // stage 1 inputs
  logic                    ld_mul, ld_lin;
  logic signed [MC_W-1:0]  mc_d;
  logic        [MR_W-1:0]  mr_d;
  logic signed [ACC_W-1:0] a_x, b_x, lin_d;

  always_comb begin
    ld_mul = in_valid && f_uses_mul(op);
    ld_lin = in_valid && f_uses_lin(op);
    mc_d = '0;
    mr_d = '0;
    if (op == OP_LERP) begin
      mc_d = signed'({2'b00, opb}) - signed'({2'b00, opa});
      mr_d[WGT_W-1:0] = wgt;
    end else begin
      mc_d[W-1:0] = opa;
      mr_d[W-1:0] = opb;
    end
    a_x = '0;
    b_x = '0;
    a_x[W-1:0] = opa;
    b_x[W-1:0] = opb;
    case (op)
      OP_ADD:  lin_d = a_x + b_x;
      OP_SUB:  lin_d = a_x - b_x;
      OP_SAD:  lin_d = (a_x >= b_x) ? (a_x - b_x) : (b_x - a_x);
      default: lin_d = a_x;
    endcase
  end

  // stage 1 registers
  logic                     s1_valid, s1_clr;
  logic [2:0]               s1_code;
  logic signed [ACC_W-1:0]  lin_q;
  logic [ND-1:0][ACC_W-1:0] pp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_clr   <= 1'b0;
      s1_code  <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_clr   <= acc_clr;
      s1_code  <= op;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lin_q <= '0;
    else if (ld_lin) lin_q <= lin_d;
  end

  mmau_booth_gen #(.MC_W(MC_W), .MR_W(MR_W), .ACC_W(ACC_W), .ND(ND)) u_gen (
    .clk(clk), .rst_n(rst_n), .load(ld_mul), .mc(mc_d), .mr(mr_d), .pp_q(pp_q)
  );

  // stage 2
  logic                    s2_valid, s2_clr;
  logic [2:0]              s2_code;
  logic signed [ACC_W-1:0] s2_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_clr   <= 1'b0;
      s2_code  <= '0;
    end else begin
      s2_valid <= s1_valid;
      s2_clr   <= s1_clr;
      s2_code  <= s1_code;
    end
  end

  mmau_reduce #(.ND(ND), .ACC_W(ACC_W), .WGT_W(WGT_W)) u_red (
    .clk(clk), .rst_n(rst_n), .en(s1_valid), .code(s1_code),
    .pp_q(pp_q), .lin_q(lin_q), .val_q(s2_val)
  );

  // stage 3
  mmau_accum #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .s2_valid(s2_valid), .s2_code(s2_code),
    .s2_clr(s2_clr), .s2_val(s2_val), .result(result), .out_valid(out_valid)
  );

endmodule

// File: rtl/mm_arith_unit_chk.sv
module mm_arith_unit_chk import mmau_pkg::*; #(
  parameter int ACC_W = 24,
  parameter int ND    = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic [2:0]               op,
  input logic [ACC_W-1:0]         result,
  input logic                     out_valid,
  input logic [ND-1:0][ACC_W-1:0] pp_q,
  input logic [ACC_W-1:0]         lin_q
);

  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_reset_state_R11: assert property (@(posedge clk)
    !rst_n |-> (result == '0 && !out_valid));

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (out_valid == ($past(in_valid, 3) && f_legal($past(op, 3)))));

  assert_illegal_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && $past(in_valid, 3) && !f_legal($past(op, 3)))
      |-> (!out_valid && result == '0));

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && !$past(in_valid, 3)) |-> (!out_valid && $stable(result)));

  assert_pp_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !f_uses_mul(op)) |=> $stable(pp_q));

  assert_lin_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !f_uses_lin(op)) |=> $stable(lin_q));

endmodule

bind mm_arith_unit mm_arith_unit_chk #(.ACC_W(ACC_W), .ND(ND)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .result(result),
  .out_valid(out_valid), .pp_q(pp_q), .lin_q(lin_q)
);

// File: tb/tb_mm_arith_unit.sv
module tb_mm_arith_unit;

  localparam int W     = 8;
  localparam int WGT_W = 8;
  localparam int ACC_W = 24;
  localparam time CYC  = 20ns;

  logic             clk;
  logic             rst_n;
  logic             in_valid;
  logic [2:0]       op;
  logic             acc_clr;
  logic [W-1:0]     opa, opb;
  logic [WGT_W-1:0] wgt;
  logic [ACC_W-1:0] result;
  logic             out_valid;

  mm_arith_unit #(.W(W), .WGT_W(WGT_W), .ACC_W(ACC_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .acc_clr(acc_clr),
    .opa(opa), .opb(opb), .wgt(wgt), .result(result), .out_valid(out_valid)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  // expected-value pipe, index 2 is due at the current negedge
  logic             pv [3];
  logic [ACC_W-1:0] pr [3];
  string            pt [3];
  logic [ACC_W-1:0] m_acc;
  logic [ACC_W-1:0] m_last;

  initial clk = 1'b0;
  always #(CYC/2) clk = ~clk;

  task automatic check_due();
    n_checks++;
    if (out_valid !== pv[2] || result !== pr[2]) begin
      n_fails++;
      $display("FAIL %s: actual valid=%0b result=%h expected valid=%0b result=%h",
               pt[2], out_valid, result, pv[2], pr[2]);
    end
  endtask

  task automatic beat(input bit v, input logic [2:0] o, input int a, input int b,
                      input int w, input bit clr, input string tag_ovr);
    logic             ev;
    logic [ACC_W-1:0] er;
    string            tg;
    @(negedge clk);
    check_due();
    pv[2] = pv[1]; pr[2] = pr[1]; pt[2] = pt[1];
    pv[1] = pv[0]; pr[1] = pr[0]; pt[1] = pt[0];
    in_valid = v; op = o; opa = W'(a); opb = W'(b); wgt = WGT_W'(w); acc_clr = clr;
    if (clr) m_acc = '0;
    ev = 1'b1;
    if (!v) begin
      ev = 1'b0; er = m_last; tg = clr ? "R9" : "R12";
    end else begin
      case (o)
        3'b000: begin er = ACC_W'(a + b); tg = "R1"; end
        3'b010: begin er = ACC_W'(a - b); tg = "R2"; end
        3'b001: begin er = ACC_W'(a * b); tg = "R3"; end
        3'b111: begin m_acc = m_acc + ACC_W'(a * b); er = m_acc; tg = "R4"; end
        3'b100: begin m_acc = m_acc + ACC_W'((a > b) ? a - b : b - a); er = m_acc; tg = "R5"; end
        3'b110: begin er = ACC_W'((a * (256 - w) + b * w) >> 8); tg = "R6"; end
        default: begin er = '0; ev = 1'b0; tg = "R7"; end
      endcase
      m_last = er;
    end
    if (tag_ovr != "") tg = tag_ovr;
    pv[0] = ev; pr[0] = er; pt[0] = tg;
  endtask

  initial begin
    #(CYC * 200000);
    if (!done) begin
      n_fails++;
      $display("FAIL R8 watchdog: actual run still busy expected run complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int seed;
    rst_n = 1'b1; in_valid = 1'b0; op = '0; acc_clr = 1'b0;
    opa = '0; opb = '0; wgt = '0;
    m_acc = '0; m_last = '0;
    for (int i = 0; i < 3; i++) begin pv[i] = 1'b0; pr[i] = '0; pt[i] = "R11"; end
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || result !== '0) begin
      n_fails++;
      $display("FAIL R11: actual valid=%0b result=%h expected valid=0 result=0", out_valid, result);
    end
    rst_n = 1'b1;

    // reset-state output during first cycles (R11), then directed cases
    beat(0, 3'b000, 0, 0, 0, 0, "R11");
    beat(1, 3'b000, 255, 255, 0, 0, "");        // R1
    beat(1, 3'b000, 0, 0, 0, 0, "");            // R1
    beat(1, 3'b010, 0, 255, 0, 0, "");          // R2
    beat(1, 3'b010, 200, 13, 0, 0, "");         // R2
    beat(1, 3'b001, 255, 255, 0, 0, "");        // R3
    beat(1, 3'b001, 0, 173, 0, 0, "");          // R3
    beat(1, 3'b001, 128, 2, 0, 0, "");          // R3
    beat(1, 3'b110, 10, 250, 0, 0, "");         // R6 w=0
    beat(1, 3'b110, 10, 250, 255, 0, "");       // R6 w=255
    beat(1, 3'b110, 10, 250, 128, 0, "");       // R6
    beat(1, 3'b110, 250, 10, 77, 0, "");        // R6 falling pair
    beat(1, 3'b111, 3, 4, 0, 1, "R9");          // R4 start with clear
    beat(1, 3'b111, 5, 6, 0, 0, "");            // R4
    beat(1, 3'b111, 255, 255, 0, 0, "");        // R4
    beat(0, 3'b000, 0, 0, 0, 0, "");            // R12
    beat(0, 3'b000, 0, 0, 0, 0, "");            // R12
    beat(0, 3'b000, 0, 0, 0, 1, "");            // R9 bare clear
    beat(1, 3'b100, 10, 3, 0, 0, "R9");         // after clear
    beat(1, 3'b100, 3, 10, 0, 0, "");           // R5
    beat(1, 3'b111, 2, 2, 0, 0, "R5");          // shared accumulator
    beat(1, 3'b100, 100, 0, 0, 1, "R9");        // clear riding on beat
    beat(1, 3'b011, 9, 9, 0, 0, "");            // R7
    beat(1, 3'b101, 9, 9, 0, 0, "");            // R7
    beat(1, 3'b000, 1, 2, 0, 0, "R8");
    beat(1, 3'b001, 7, 9, 0, 0, "R8");
    beat(1, 3'b010, 40, 1, 99, 0, "R10");
    beat(1, 3'b000, 17, 3, 55, 0, "R10");
    beat(1, 3'b100, 8, 200, 13, 0, "R10");
    beat(1, 3'b001, 7, 9, 0, 0, "R10");         // product after frozen run
    beat(1, 3'b111, 11, 12, 0, 1, "R10");
    beat(1, 3'b000, 6, 6, 0, 0, "R10");         // linear term after frozen run

    seed = 32'h1F2E3D;
    void'($urandom(seed));
    for (int k = 0; k < 3000; k++) begin
      bit v, c;
      v = ($urandom % 8) != 0;
      c = ($urandom % 16) == 0;
      beat(v, 3'($urandom), int'($urandom % 256), int'($urandom % 256),
           int'($urandom % 256), c, "");
    end
    for (int k = 0; k < 3; k++) beat(0, 3'b000, 0, 0, 0, 0, "");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule